// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a single-port static memory of 32-bit words. Each word is split into four byte lanes. Address, control and write data are registered on the rising clock edge. Read data has no output register: it flows from the array during the same cycle that follows the edge that captured the address. One captured address can serve four data beats. A two-bit beat counter produces the three follow-on addresses, either in linear order or in interleaved order.

A cycle starts with one of two address strobes. The processor strobe always starts a read and ignores the write controls. The controller strobe honours the write controls. Once a burst has started and no new strobe arrives, the advance input either steps the beat counter or holds it. The write controls sampled in that cycle decide whether the beat reads or writes. Three levels of write enable are provided: global write, byte-write enable and per-lane selects.

Two inputs suppress activity. The sleep input stops all access and ends any burst. Chip enable turns a strobe cycle into a deselect. Output enable blanks the data bus without disturbing the burst. A valid flag tells the user whether the word on the read bus is meaningful.

Top module: `burst_sram`

## Requirements
- R1: After reset no access is active, so `rvalid` is 0 and `rdata` is 0.
- R2: A read captured at edge k (strobe low, `ce_n` low, no write) shows `mem[addr]` on `rdata` with `rvalid`=1 during the cycle that follows edge k. A write captured at edge k stores its data at edge k+1, and a later read returns it.
- R3: In linear order (`order_ilv`=0 at the strobe edge), each later edge with `adv_n` low and no strobe adds 1 modulo 4 to the low two address bits. The upper bits stay fixed. The fifth beat wraps back to the start address.
- R4: In interleaved order (`order_ilv`=1 at the strobe edge), the low two address bits are the start bits XOR the beat count 0,1,2,3. Starting from low bits 2'b10, the order is 10, 11, 00, 01.
- R5: With `adv_n` high and no strobe, an active burst keeps its current address.
- R6: With `gw_n` low, a write cycle stores all four lanes, whatever `bwe_n` and `bsel_n` hold.
- R7: With `gw_n` high and `bwe_n` low, only lane i is stored for each `bsel_n[i]`=0, where lane i is bits [8i+7:8i]. With `gw_n` and `bwe_n` both high, the cycle is a read.
- R8: A processor strobe starts a read even when write controls are active. It takes priority when both strobes are low.
- R9: A strobe sampled with `ce_n` high is a deselect. It ends any burst, after which `rvalid` is 0 and nothing is written until a new strobe.
- R10: While `sleep` is high, no write reaches the array and `rvalid` is 0 in the same cycle. An edge with `sleep` high ends any burst, including a write that was captured but not yet stored.
- R11: While `oe_n` is high, `rdata` is 0 and `rvalid` is 0 in the same cycle.
- R12: A new strobe during a burst abandons that burst and restarts at the new address with beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control registers |
| addr | input | AW | Word address, AW = log2(DEPTH) |
| ce_n | input | 1 | Chip enable, active low, sampled on strobe cycles |
| strobe_cpu_n | input | 1 | Processor address strobe, active low, read only |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Power-down request, active high |
| wdata | input | 32 | Write data, registered with the controls |
| rdata | output | 32 | Flow-through read data, zero when not valid |
| rvalid | output | 1 | High when `rdata` holds a word read from the array |

## Verification
Read data is due in the cycle right after the edge that captured its address. Write data reaches the array one edge after it was captured. `oe_n` and `sleep` act on the outputs in the same cycle. A reference model in the bench mirrors these latencies: the driver computes each cycle's expected output from the model's registered state and the inputs currently applied. The monitor compares `rdata` and `rvalid` against that expectation at the falling edge, halfway between the capturing edges. Burst orders, wrap-around, byte masks and suppressed writes are checked by reading back through normal read cycles.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int LANES     = 4;
    localparam int LANE_W    = 8;
    localparam int WORD_W    = LANES * LANE_W;
    localparam int BEAT_W    = 2;

    // Low two address bits of the current beat
    function automatic logic [BEAT_W-1:0] beat_lo(
        input logic [BEAT_W-1:0] start_lo,
        input logic [BEAT_W-1:0] beat,
        input logic              interleaved
    );
        if (interleaved) begin
            return start_lo ^ beat;
        end
        return start_lo + beat;
    endfunction

endpackage

// File: rtl/bsram_wr_decode.sv
module bsram_wr_decode
    import bsram_pkg::*;
(
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    output logic             is_write,
    output logic [LANES-1:0] lanes
);

    always_comb begin
        if (!gw_n) begin
            is_write = 1'b1;
            lanes    = '1;
        end else if (!bwe_n) begin
            is_write = 1'b1;
            lanes    = ~bsel_n;
        end else begin
            is_write = 1'b0;
            lanes    = '0;
        end
    end

endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              ce_n,
    input  logic              strobe_cpu_n,
    input  logic              strobe_ctl_n,
    input  logic              adv_n,
    input  logic              order_ilv,
    input  logic [AW-1:0]     addr,
    input  logic              dec_write,
    input  logic [LANES-1:0]  dec_lanes,
    input  logic [WORD_W-1:0] wdata,
    output logic              acc_active,
    output logic              acc_write,
    output logic [LANES-1:0]  acc_lanes,
    output logic [WORD_W-1:0] acc_wdata,
    output logic [AW-1:0]     acc_base,
    output logic [BEAT_W-1:0] acc_beat,
    output logic              acc_ilv
);

    typedef struct packed {
        logic              active;
        logic              write;
        logic [LANES-1:0]  lanes;
        logic [WORD_W-1:0] wdata;
        logic [AW-1:0]     base;
        logic [BEAT_W-1:0] beat;
        logic              ilv;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.wdata = wdata;
        if (sleep) begin
            st_d.active = 1'b0;
            st_d.write  = 1'b0;
            st_d.lanes  = '0;
        end else if (!strobe_cpu_n) begin
            if (ce_n) begin
                st_d.active = 1'b0;
                st_d.write  = 1'b0;
                st_d.lanes  = '0;
            end else begin
                st_d.active = 1'b1;
                st_d.write  = 1'b0;
                st_d.lanes  = '0;
                st_d.base   = addr;
                st_d.beat   = '0;
                st_d.ilv    = order_ilv;
            end
        end else if (!strobe_ctl_n) begin
            if (ce_n) begin
                st_d.active = 1'b0;
                st_d.write  = 1'b0;
                st_d.lanes  = '0;
            end else begin
                st_d.active = 1'b1;
                st_d.write  = dec_write;
                st_d.lanes  = dec_lanes;
                st_d.base   = addr;
                st_d.beat   = '0;
                st_d.ilv    = order_ilv;
            end
        end else if (st_q.active) begin
            if (!adv_n) begin
                st_d.beat = st_q.beat + 1'b1;
            end
            st_d.write = dec_write;
            st_d.lanes = dec_lanes;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_active = st_q.active;
    assign acc_write  = st_q.write;
    assign acc_lanes  = st_q.lanes;
    assign acc_wdata  = st_q.wdata;
    assign acc_base   = st_q.base;
    assign acc_beat   = st_q.beat;
    assign acc_ilv    = st_q.ilv;

endmodule

// File: rtl/bsram_addr_gen.sv
module bsram_addr_gen
    import bsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [AW-1:0]     base,
    input  logic [BEAT_W-1:0] beat,
    input  logic              ilv,
    output logic [AW-1:0]     cur_addr
);

    always_comb begin
        cur_addr               = base;
        cur_addr[BEAT_W-1:0]   = beat_lo(base[BEAT_W-1:0], beat, ilv);
    end

endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import bsram_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic              clk,
    input  logic [AW-1:0]     addr,
    input  logic [LANES-1:0]  we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rword
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rword[g*LANE_W +: LANE_W] = cells[addr];
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              ce_n,
    input  logic              strobe_cpu_n,
    input  logic              strobe_ctl_n,
    input  logic              adv_n,
    input  logic              order_ilv,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bsel_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);

    logic              dec_write;
    logic [LANES-1:0]  dec_lanes;
    logic              acc_active;
    logic              acc_write;
    logic [LANES-1:0]  acc_lanes;
    logic [WORD_W-1:0] acc_wdata;
    logic [AW-1:0]     acc_base;
    logic [BEAT_W-1:0] acc_beat;
    logic              acc_ilv;
    logic [AW-1:0]     cur_addr;
    logic [LANES-1:0]  mem_we;
    logic [WORD_W-1:0] rword;

    bsram_wr_decode u_dec (
        .gw_n     (gw_n),
        .bwe_n    (bwe_n),
        .bsel_n   (bsel_n),
        .is_write (dec_write),
        .lanes    (dec_lanes)
    );

    bsram_ctrl #(.AW(AW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep        (sleep),
        .ce_n         (ce_n),
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .adv_n        (adv_n),
        .order_ilv    (order_ilv),
        .addr         (addr),
        .dec_write    (dec_write),
        .dec_lanes    (dec_lanes),
        .wdata        (wdata),
        .acc_active   (acc_active),
        .acc_write    (acc_write),
        .acc_lanes    (acc_lanes),
        .acc_wdata    (acc_wdata),
        .acc_base     (acc_base),
        .acc_beat     (acc_beat),
        .acc_ilv      (acc_ilv)
    );

    bsram_addr_gen #(.AW(AW)) u_agen (
        .base     (acc_base),
        .beat     (acc_beat),
        .ilv      (acc_ilv),
        .cur_addr (cur_addr)
    );

    // Registered write commits at the next edge unless asleep
    assign mem_we = acc_lanes & {LANES{acc_active & acc_write & ~sleep}};

    bsram_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk   (clk),
        .addr  (cur_addr),
        .we    (mem_we),
        .wdata (acc_wdata),
        .rword (rword)
    );

    // Flow-through read path, blanked by output enable and sleep
    assign rvalid = acc_active & ~acc_write & ~oe_n & ~sleep;
    assign rdata  = rvalid ? rword : '0;

endmodule

// File: rtl/bsram_chk.sv
module bsram_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sleep,
    input logic        oe_n,
    input logic        ce_n,
    input logic        strobe_cpu_n,
    input logic        strobe_ctl_n,
    input logic        adv_n,
    input logic        rvalid,
    input logic [31:0] rdata,
    input logic        acc_active,
    input logic [1:0]  acc_beat,
    input logic [3:0]  mem_we
);

    assert_oe_blank_R11: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (rdata == 32'd0 && !rvalid));

    assert_sleep_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (mem_we == 4'd0 && !rvalid));

    assert_sleep_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !acc_active);

    assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_active && strobe_cpu_n && strobe_ctl_n && !adv_n && !sleep)
        |=> (acc_active && acc_beat == 2'($past(acc_beat) + 2'd1)));

    assert_suspend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_active && strobe_cpu_n && strobe_ctl_n && adv_n && !sleep)
        |=> (acc_active && $stable(acc_beat)));

    assert_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && (!strobe_cpu_n || !strobe_ctl_n) && !sleep)
        |=> (!acc_active && mem_we == 4'd0 && !rvalid));

    assert_cpu_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_cpu_n && !ce_n && !sleep)
        |=> (acc_active && acc_beat == 2'd0 && mem_we == 4'd0));

    assert_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_ctl_n && !ce_n && !sleep) |=> (acc_active && acc_beat == 2'd0));

endmodule

bind burst_sram bsram_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep        (sleep),
    .oe_n         (oe_n),
    .ce_n         (ce_n),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .adv_n        (adv_n),
    .rvalid       (rvalid),
    .rdata        (rdata),
    .acc_active   (acc_active),
    .acc_beat     (acc_beat),
    .mem_we       (mem_we)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int AW         = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic        ce_n = 1'b0;
    logic        strobe_cpu_n = 1'b1;
    logic        strobe_ctl_n = 1'b1;
    logic        adv_n = 1'b1;
    logic        order_ilv = 1'b0;
    logic        gw_n = 1'b1;
    logic        bwe_n = 1'b1;
    logic [3:0]  bsel_n = 4'hF;
    logic        oe_n = 1'b0;
    logic        sleep = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;

    burst_sram #(.DEPTH(DEPTH)) i_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
        .adv_n(adv_n), .order_ilv(order_ilv), .gw_n(gw_n), .bwe_n(bwe_n),
        .bsel_n(bsel_n), .oe_n(oe_n), .sleep(sleep), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic        v;
        logic [31:0] d;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // Reference model, written from the requirements
    logic [31:0] m_mem [DEPTH];
    logic        m_act = 0, m_wr = 0, m_ilv = 0;
    logic [3:0]  m_lanes = 0;
    logic [31:0] m_wd = 0;
    logic [AW-1:0] m_base = 0;
    logic [1:0]  m_beat = 0;

    function automatic logic [AW-1:0] m_cur();
        logic [1:0] lo;
        lo = m_ilv ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic [31:0] pat(input int a);
        return 32'h5A00_0000 ^ (32'(a) * 32'h0001_0203) ^ 32'(a);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: expectation for the current cycle, then model update at the edge
    task automatic run_cycle(input string req);
        exp_t e;
        logic [3:0] dl;
        logic dw;
        e.v   = m_act && !m_wr && !oe_n && !sleep;
        e.d   = e.v ? m_mem[m_cur()] : 32'd0;
        e.req = req;
        exp_q.push_back(e);
        @(posedge clk);
        if (m_act && m_wr && !sleep) begin
            for (int i = 0; i < 4; i++) begin
                if (m_lanes[i]) m_mem[m_cur()][i*8 +: 8] = m_wd[i*8 +: 8];
            end
        end
        dw = !gw_n || !bwe_n;
        dl = !gw_n ? 4'hF : (!bwe_n ? ~bsel_n : 4'h0);
        m_wd = wdata;
        if (sleep) begin
            m_act = 0; m_wr = 0;
        end else if (!strobe_cpu_n) begin
            if (ce_n) begin m_act = 0; m_wr = 0; end
            else begin m_act = 1; m_wr = 0; m_lanes = 0; m_base = addr; m_beat = 0; m_ilv = order_ilv; end
        end else if (!strobe_ctl_n) begin
            if (ce_n) begin m_act = 0; m_wr = 0; end
            else begin m_act = 1; m_wr = dw; m_lanes = dl; m_base = addr; m_beat = 0; m_ilv = order_ilv; end
        end else if (m_act) begin
            if (!adv_n) m_beat = m_beat + 2'd1;
            m_wr = dw; m_lanes = dl;
        end
        #1;
    endtask

    task automatic idle_in();
        ce_n = 0; strobe_cpu_n = 1; strobe_ctl_n = 1; adv_n = 1; order_ilv = 0;
        gw_n = 1; bwe_n = 1; bsel_n = 4'hF; oe_n = 0; sleep = 0;
    endtask

    task automatic ctl(input int a, input logic g, input logic b, input logic [3:0] s,
                       input logic [31:0] d, input logic ilv, input string req);
        idle_in(); strobe_ctl_n = 0; addr = AW'(a); gw_n = g; bwe_n = b; bsel_n = s;
        wdata = d; order_ilv = ilv; run_cycle(req);
    endtask

    task automatic cpu(input int a, input logic ilv, input string req);
        idle_in(); strobe_cpu_n = 0; addr = AW'(a); order_ilv = ilv; run_cycle(req);
    endtask

    task automatic cont(input logic adv, input logic g, input logic [31:0] d, input string req);
        idle_in(); adv_n = adv; gw_n = g; wdata = d; run_cycle(req);
    endtask

    // Monitor: compares at the falling edge, between capturing edges
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(rvalid === e.v, {e.req, " rvalid"}, 32'(rvalid), 32'(e.v));
                check(rdata === e.d, {e.req, " rdata"}, rdata, e.d);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle_in();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rvalid === 1'b0 && rdata === 32'd0, "R1 reset outputs", rdata, 32'd0);
        @(posedge clk); #1;
        rst_n = 1;
        cont(1, 1, 0, "R1 idle after reset");

        // R2: single writes then read back
        for (int a = 0; a < 16; a++) ctl(a, 0, 1, 4'hF, pat(a), 0, "R2 write");
        cont(1, 1, 0, "R2 commit");
        cpu(2, 0, "R2 read");
        cont(1, 1, 0, "R2 flow-through");
        // Burst write 16..19
        ctl(16, 0, 1, 4'hF, pat(16), 0, "R3 burst write");
        for (int k = 17; k < 20; k++) cont(0, 0, pat(k), "R3 burst write");
        cont(1, 1, 0, "R3 commit");
        cpu(16, 0, "R3 read burst");
        for (int k = 0; k < 3; k++) cont(0, 1, 0, "R3 read burst");

        // R3: linear from 9: 9,10,11,8 then wrap to 9
        cpu(9, 0, "R3 linear start");
        for (int k = 0; k < 4; k++) cont(0, 1, 0, "R3 linear beat");
        cont(1, 1, 0, "R3 wrap");

        // R4: interleaved from 10: 10,11,8,9
        ctl(10, 1, 1, 4'hF, 0, 1, "R4 interleaved start");
        for (int k = 0; k < 3; k++) cont(0, 1, 0, "R4 interleaved beat");
        cont(1, 1, 0, "R4 last beat");

        // R5: suspend
        cpu(12, 0, "R5 start");
        cont(1, 1, 0, "R5 hold");
        cont(1, 1, 0, "R5 hold");
        cont(0, 1, 0, "R5 advance");
        cont(1, 1, 0, "R5 after advance");

        // R6: global write overrides lane selects
        ctl(20, 0, 0, 4'b0101, 32'h1122_3344, 0, "R6 write");
        cpu(20, 0, "R6 readback");
        cont(1, 1, 0, "R6 readback");
        // R7: lanes 0 and 2 only; then a read-type controller cycle
        ctl(21, 1, 0, 4'b1010, 32'hAABB_CCDD, 0, "R7 byte write");
        cpu(21, 0, "R7 readback");
        cont(1, 1, 0, "R7 readback");
        ctl(22, 1, 1, 4'h0, 32'hFFFF_FFFF, 0, "R7 read cycle");
        cont(1, 1, 0, "R7 no write");

        // R8: processor strobe ignores write controls and wins
        idle_in(); strobe_cpu_n = 0; addr = 6'd3; gw_n = 0; wdata = 32'hDEAD_0003; run_cycle("R8 cpu with gw");
        cont(1, 1, 0, "R8 read");
        idle_in(); strobe_cpu_n = 0; strobe_ctl_n = 0; addr = 6'd4; gw_n = 0; wdata = 32'hDEAD_0004;
        run_cycle("R8 both strobes");
        cont(1, 1, 0, "R8 read");
        cpu(3, 0, "R8 unchanged");
        cpu(4, 0, "R8 unchanged");

        // R9: deselect ends burst
        cpu(5, 0, "R9 start");
        cont(0, 1, 0, "R9 beat");
        idle_in(); ce_n = 1; strobe_ctl_n = 0; addr = 6'd6; gw_n = 0; run_cycle("R9 deselect");
        cont(0, 1, 0, "R9 idle");
        cont(0, 0, 32'h0BAD_0000, "R9 no write");
        cpu(6, 0, "R9 check");

        // R10: sleep blanks output, ends burst, blocks a pending write
        cpu(6, 0, "R10 start");
        idle_in(); sleep = 1; adv_n = 0; run_cycle("R10 asleep");
        cont(0, 1, 0, "R10 burst ended");
        ctl(7, 0, 1, 4'hF, 32'hDEAD_0007, 0, "R10 write");
        idle_in(); sleep = 1; run_cycle("R10 suppressed");
        cpu(7, 0, "R10 unchanged");
        cont(1, 1, 0, "R10 unchanged");

        // R11: output enable blanking
        cpu(8, 0, "R11 start");
        idle_in(); oe_n = 1; adv_n = 0; run_cycle("R11 blank");
        cont(1, 1, 0, "R11 restored");

        // R12: new strobe mid-burst
        cpu(0, 0, "R12 first");
        cont(0, 1, 0, "R12 first beat");
        cpu(13, 1, "R12 restart");
        cont(0, 1, 0, "R12 new beat");
        cont(1, 1, 0, "R12 new beat");

        cont(1, 1, 0, "drain");
        @(negedge clk); @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule